// File: doc/BRIEF.md
# Three-Wire Half-Duplex SPI Master

This block is a SPI master for exactly one peripheral that uses a single shared data line in both directions. The host starts a transaction with two byte counts: how many bytes go out and how many come back. The block lowers an active-low chip select. It clocks the outgoing bytes onto the shared line, then releases the line and clocks the incoming bytes in. All of this happens under one chip-select assertion.

The shared line is wired-AND. The block never drives it high. It has a drive-low enable that an external open-drain stage turns into a pull-down, and a pull-up supplies the high level. The sensed line comes back through an external inverting stage, so the block complements every sampled bit before storing it.

The clock runs in SPI mode 0 and its half-period is set by a programmable divider. The host supplies outgoing bytes through a take-strobe handshake. It receives incoming bytes with a one-cycle valid strobe, and is told the transaction has ended by a one-cycle done pulse.

Top module: `tw_spi3_master`

## Requirements
- R1: After reset and while idle, `cs_n_o`=1, `sclk_o`=0, `line_pull_o`=0, `busy_o`=0, `done_o`=0.
- R2: Clock timing and data changes:
  - `sclk_o` idles low. Each of its high and low half-periods inside a byte lasts `half_div_i`+1 clock cycles.
  - `line_pull_o` changes only in a cycle where `sclk_o` falls or `cs_n_o` changes, so data is stable at every rising edge.
- R3: `cs_n_o` falls once and rises once per transaction and is low whenever `sclk_o` or `line_pull_o` is high. `sclk_o` gives exactly 8×(write count + read count) rising edges.
- R4: Write bytes go out most significant bit first. `line_pull_o`=1 exactly when the current write bit is 0, and 0 when it is 1.
- R5: All write bytes come before all read bytes. During every read bit `line_pull_o`=0.
- R6: On each rising `sclk_o` edge of the read phase, the stored bit is the complement of `line_sense_i`. Read bytes are assembled MSB first. Each completed byte appears on `rd_data_o` with a one-cycle `rd_valid_o` pulse.
- R7: `wr_next_o` pulses once per write byte, in the cycle whose closing clock edge captures `wr_data_i`. The first pulse comes in the cycle `start_i` is accepted.
- R8: Counts of zero are legal. With both counts zero, `cs_n_o` goes low for `half_div_i`+1 cycles and then returns high, with no `sclk_o` pulse.
- R9: `done_o` is high for exactly one cycle: the first cycle in which `cs_n_o` is high again. `busy_o` is high from the cycle after acceptance through that done cycle.
- R10: `start_i` is ignored while `busy_o` is high. Counts presented then do not change the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction when idle |
| wr_count_i | input | CNT_W | Number of bytes to send |
| rd_count_i | input | CNT_W | Number of bytes to receive |
| half_div_i | input | DIV_W | Clock half-period minus one, in cycles |
| wr_data_i | input | DATA_W | Next byte to send |
| wr_next_o | output | 1 | `wr_data_i` is taken at the coming edge |
| rd_data_o | output | DATA_W | Last received byte |
| rd_valid_o | output | 1 | `rd_data_o` holds a new byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sclk_o | output | 1 | Serial clock, mode 0 |
| cs_n_o | output | 1 | Active-low chip select |
| line_pull_o | output | 1 | Drive-low enable for the shared data line |
| line_sense_i | input | 1 | Inverted sensed level of the shared line |

## Verification
The bench places a wired-AND line model around the block, with an inverting sense path and a peripheral that receives the written bits and drives response bits after each falling edge.

Directed cases try both counts zero, write-only, read-only, the largest counts, and the shortest divider setting. These separate the phase-sequencing decisions from the shifting itself.

Seeded random transactions mix counts, divider values and byte values. Byte values with zero and one bits in every position show whether bit order, the pull-when-zero encoding and the read inversion are all right.

A second start with different counts during a transaction shows whether it leaks into the edge count.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_FIN
  } tw_state_e;
endpackage

// File: rtl/tw_spi_divider.sv
module tw_spi_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_q, half_d;

  assign tick_o = run_i && (cnt_q == half_q);

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (!run_i) begin
      cnt_d  = '0;
      half_d = half_i;
    end else if (tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= half_q));
endmodule

// File: rtl/tw_spi_shifter.sv
module tw_spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              sense_i,
  output logic              tx_msb_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              last_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  assign tx_msb_o  = tx_q[DATA_W-1];
  assign rx_byte_o = rx_q;
  assign last_o    = (bit_q == BIT_W'(DATA_W-1));

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    bit_d = bit_q;
    if (load_i) begin
      tx_d  = tx_byte_i;
      bit_d = '0;
    end else if (fall_i) begin
      tx_d  = {tx_q[DATA_W-2:0], 1'b0};
      bit_d = bit_q + BIT_W'(1);
    end
    if (rise_i) begin
      rx_d = {rx_q[DATA_W-2:0], ~sense_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      bit_q <= bit_d;
    end
  end

  // R6
  rx_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (rx_q[0] == !$past(sense_i)));
  // R4
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (tx_msb_o == $past(tx_byte_i[DATA_W-1])) && (bit_q == '0));
endmodule

// File: rtl/tw_spi_ctrl.sv
module tw_spi_ctrl
  import tw_spi_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  input  logic             tick_i,
  input  logic             last_i,
  output logic             run_o,
  output logic             load_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             shifting_o,
  output logic             phase_wr_o,
  output logic             wr_next_o,
  output logic             rd_end_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             done_o
);
  tw_state_e        state_q, state_d;
  logic [CNT_W-1:0] wl_q, wl_d, rl_q, rl_d;
  logic [CNT_W-1:0] cand_wr, cand_rd;
  logic             ph_q, ph_d;
  logic             sclk_q, csn_q, done_q;
  logic             idle, byte_end, pick;

  assign idle       = (state_q == ST_IDLE);
  assign byte_end   = (state_q == ST_HIGH) && tick_i && last_i;
  assign pick       = (idle && start_i) || byte_end;
  assign cand_wr    = idle ? wr_cnt_i : wl_q;
  assign cand_rd    = idle ? rd_cnt_i : rl_q;
  assign run_o      = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TAIL);
  assign shifting_o = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign rise_o     = (state_q == ST_LOW) && tick_i;
  assign fall_o     = (state_q == ST_HIGH) && tick_i;
  assign phase_wr_o = ph_q;
  assign rd_end_o   = byte_end && !ph_q;
  assign busy_o     = !idle;
  assign sclk_o     = sclk_q;
  assign cs_n_o     = csn_q;
  assign done_o     = done_q;

  always_comb begin
    state_d   = state_q;
    wl_d      = wl_q;
    rl_d      = rl_q;
    ph_d      = ph_q;
    load_o    = 1'b0;
    wr_next_o = 1'b0;
    unique case (state_q)
      ST_IDLE: state_d = ST_IDLE;
      ST_LOW:  if (tick_i) state_d = ST_HIGH;
      ST_HIGH: if (tick_i && !last_i) state_d = ST_LOW;
      ST_TAIL: if (tick_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (pick) begin
      wl_d = cand_wr;
      rl_d = cand_rd;
      if (cand_wr != '0) begin
        wl_d      = cand_wr - CNT_W'(1);
        ph_d      = 1'b1;
        load_o    = 1'b1;
        wr_next_o = 1'b1;
        state_d   = ST_LOW;
      end else if (cand_rd != '0) begin
        rl_d    = cand_rd - CNT_W'(1);
        ph_d    = 1'b0;
        load_o  = 1'b1;
        state_d = ST_LOW;
      end else begin
        state_d = ST_TAIL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wl_q    <= '0;
      rl_q    <= '0;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wl_q    <= wl_d;
      rl_q    <= rl_d;
      ph_q    <= ph_d;
      sclk_q  <= (state_d == ST_HIGH);
      csn_q   <= (state_d == ST_IDLE) || (state_d == ST_FIN);
      done_q  <= (state_d == ST_FIN);
    end
  end

  // R3
  sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);
  // R9
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !$past(cs_n_o)));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/tw_spi3_master.sv
module tw_spi3_master #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  wr_count_i,
  input  logic [CNT_W-1:0]  rd_count_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_next_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              line_pull_o,
  input  logic              line_sense_i
);
  logic              rst_meta_q, rst_sync_q;
  logic              tick, last, run, load, rise, fall, shifting, phase_wr, rd_end;
  logic              tx_msb;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic              rd_valid_q, rd_valid_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  tw_spi_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .run_i  (run),
    .half_i (half_div_i),
    .tick_o (tick)
  );

  tw_spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (load),
    .rise_i    (rise),
    .fall_i    (fall),
    .tx_byte_i (wr_data_i),
    .sense_i   (line_sense_i),
    .tx_msb_o  (tx_msb),
    .rx_byte_o (rx_byte),
    .last_o    (last)
  );

  tw_spi_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start_i),
    .wr_cnt_i   (wr_count_i),
    .rd_cnt_i   (rd_count_i),
    .tick_i     (tick),
    .last_i     (last),
    .run_o      (run),
    .load_o     (load),
    .rise_o     (rise),
    .fall_o     (fall),
    .shifting_o (shifting),
    .phase_wr_o (phase_wr),
    .wr_next_o  (wr_next_o),
    .rd_end_o   (rd_end),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // pull low only for a zero bit of the write phase
  assign line_pull_o = shifting && phase_wr && !tx_msb;
  assign rd_data_o   = rd_data_q;
  assign rd_valid_o  = rd_valid_q;

  always_comb begin
    rd_valid_d = rd_end;
    rd_data_d  = rd_data_q;
    if (rd_end) rd_data_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  // R3
  pull_cs_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    line_pull_o |-> !cs_n_o);
  // R7
  wr_next_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wr_next_o |=> busy_o);
  // R6
  rd_valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rd_valid_o |-> (busy_o && !cs_n_o));
endmodule

// File: tb/tw_spi3_master_test.sv
module tw_spi3_master_test;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [CW-1:0] wr_count_i, rd_count_i;
  logic [VW-1:0] half_div_i;
  logic [DW-1:0] wr_data_i, rd_data_o;
  logic          wr_next_o, rd_valid_o, busy_o, done_o, sclk_o, cs_n_o, line_pull_o, line_sense_i;
  logic          sl_pull, line;

  logic [7:0] wbuf [16];
  logic [7:0] resp [16];
  logic [7:0] cap  [16];
  logic [7:0] got  [16];
  int t_wr, t_rd, t_half, widx, ridx;
  int rise_n, fall_n, csfall_n, csrise_n, done_n, wnext_n, hi_len, hi_bad, pull_bad, rd_pull_bad, done_bad;
  logic prev_sclk, prev_cs, prev_pull;
  int n_chk, n_err;

  always #4 clk = ~clk;

  tw_spi3_master #(.DATA_W(DW), .CNT_W(CW), .DIV_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_count_i(wr_count_i),
    .rd_count_i(rd_count_i), .half_div_i(half_div_i), .wr_data_i(wr_data_i),
    .wr_next_o(wr_next_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
    .line_pull_o(line_pull_o), .line_sense_i(line_sense_i)
  );

  // peripheral: drives response bit index fall_n inside the read window
  always_comb begin
    int b;
    b = fall_n - t_wr * 8;
    sl_pull = 1'b0;
    if (!cs_n_o && b >= 0 && b < t_rd * 8)
      sl_pull = !resp[b / 8][7 - (b % 8)];
  end
  assign line         = ~(line_pull_o | sl_pull);
  assign line_sense_i = ~line;
  assign wr_data_i    = wbuf[widx % 16];

  always @(posedge clk) if (wr_next_o) widx <= widx + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o && !prev_sclk) begin
        if (rise_n < t_wr * 8) cap[rise_n / 8][7 - (rise_n % 8)] = line;
        rise_n++;
        hi_len = 1;
      end else if (sclk_o) hi_len++;
      if (!sclk_o && prev_sclk) begin
        fall_n++;
        if (hi_len != t_half + 1) hi_bad++;
      end
      if (line_pull_o && !cs_n_o && fall_n >= t_wr * 8) rd_pull_bad++;
      if (line_pull_o != prev_pull && !(prev_sclk && !sclk_o) && cs_n_o == prev_cs) pull_bad++;
      if (!cs_n_o && prev_cs) csfall_n++;
      if (cs_n_o && !prev_cs) csrise_n++;
      if (done_o) begin
        done_n++;
        if (!(cs_n_o && !prev_cs)) done_bad++;
      end
      if (wr_next_o) wnext_n++;
      if (rd_valid_o) begin
        got[ridx % 16] = rd_data_o;
        ridx++;
      end
      prev_sclk = sclk_o;
      prev_cs   = cs_n_o;
      prev_pull = line_pull_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input int nw, input int nr, input int half, input bit poke);
    int guard;
    for (int i = 0; i < 16; i++) begin
      wbuf[i] = 8'($urandom);
      resp[i] = 8'($urandom);
      cap[i]  = 8'h00;
      got[i]  = 8'h00;
    end
    @(negedge clk);
    t_wr = nw; t_rd = nr; t_half = half;
    widx = 0; ridx = 0;
    rise_n = 0; fall_n = 0; csfall_n = 0; csrise_n = 0; done_n = 0; wnext_n = 0;
    hi_len = 0; hi_bad = 0; pull_bad = 0; rd_pull_bad = 0; done_bad = 0;
    wr_count_i = CW'(nw); rd_count_i = CW'(nr); half_div_i = VW'(half);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      wr_count_i = 4'd15; rd_count_i = 4'd15; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (done_n == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check("R9 done count", done_n, 1);
    check("R9 done with first cs high", done_bad, 0);
    check("R9 busy low after done", int'(busy_o), 0);
    check("R3 sclk rising edges", rise_n, 8 * (nw + nr));
    check("R3 cs falls", csfall_n, 1);
    check("R3 cs rises", csrise_n, 1);
    check("R2 high half-period length", hi_bad, 0);
    check("R2 data changes only at falling edge", pull_bad, 0);
    check("R5 line released in read phase", rd_pull_bad, 0);
    check("R7 write take strobes", wnext_n, nw);
    check("R6 read byte strobes", ridx, nr);
    for (int i = 0; i < nw; i++) check("R4 written byte", int'(cap[i]), int'(wbuf[i]));
    for (int i = 0; i < nr; i++) check("R6 read byte", int'(got[i]), int'(resp[i]));
    if (nw == 0 && nr == 0) check("R8 no clock on empty transaction", rise_n, 0);
    if (poke) check("R10 start while busy ignored", rise_n, 8 * (nw + nr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R9: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    n_chk = 0; n_err = 0;
    t_wr = 0; t_rd = 0; t_half = 0; widx = 0; ridx = 0;
    rise_n = 0; fall_n = 0;
    prev_sclk = 1'b0; prev_cs = 1'b1; prev_pull = 1'b0;
    for (int i = 0; i < 16; i++) begin wbuf[i] = 8'h00; resp[i] = 8'hFF; end
    start_i = 1'b0; wr_count_i = '0; rd_count_i = '0; half_div_i = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 idle state after reset
    check("R1 cs_n idle", int'(cs_n_o), 1);
    check("R1 sclk idle", int'(sclk_o), 0);
    check("R1 pull idle", int'(line_pull_o), 0);
    check("R1 busy idle", int'(busy_o), 0);
    check("R1 done idle", int'(done_o), 0);
    // directed corners
    run_txn(0, 0, 2, 1'b0);   // R8
    run_txn(1, 0, 0, 1'b0);
    run_txn(0, 1, 1, 1'b0);
    run_txn(2, 3, 0, 1'b0);
    run_txn(1, 2, 3, 1'b1);   // R10
    run_txn(15, 15, 0, 1'b0);
    // seeded random mix
    for (int k = 0; k < 15; k++)
      run_txn(int'($urandom % 7), int'($urandom % 7), int'($urandom % 4), ($urandom % 4) == 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule